// File: doc/BRIEF.md
# Windowboxing Scanout Address Generator

This block turns the pixel counters of a fixed-timing video output into framebuffer read requests. The output raster keeps one size (1920x1080 by default) and one pixel clock at all times. A smaller guest picture is placed in the middle of that raster and shown with integer pixel replication at a factor of 1, 2 or 3. Every pixel outside the picture is driven black. A 960x540 guest at factor 2 covers the whole screen, and so does a 640x360 guest at factor 3. The pixel clock is never reprogrammed.

Software writes a guest width, height and requested factor. The block clamps the size to the output, lowers the factor to the largest one that fits, and computes the window origin when the write is taken. The new mode waits in a pending register and is adopted at the first pixel of vertical blanking. Read addresses are linear, with a stride equal to the guest width and the frame starting at address 0. Each address is issued one cycle after the counters that produced it. The memory answers two cycles later, and the blank flag and pixel mux are aligned to that answer.

Top module: `scanout_windowbox`

## Requirements
- R1: While reset is held and directly after it, rdEn is 0, blankOut is 1 and pixelOut is 0. The active mode is then the full output size at factor 1.
- R2: rdEn is never 1 in the cycle after one in which activeIn was 0.
- R3: With effective size W x H and factor S, xOff = floor((OUT_W - W*S)/2) and yOff = floor((OUT_H - H*S)/2). rdEn is 1 exactly one cycle after activeIn=1 with hCount in [xOff, xOff+W*S) and vCount in [yOff, yOff+H*S).
- R4: With rdEn, rdAddr = ((vCount-yOff) div S)*W + (hCount-xOff) div S, taken from the counters one cycle earlier.
- R5: A guest of OUT_W/2 x OUT_H/2 at factor 2 reads for every active pixel, and each source pixel and line is repeated twice.
- R6: A guest of OUT_W/3 x OUT_H/3 at factor 3 reads for every active pixel, and each source pixel and line is repeated three times.
- R7: The factor field is 2 bits. Codes 0 and 1 mean 1, code 2 means 2 and code 3 means 3. A requested factor whose scaled size exceeds the output in either axis drops to the largest factor (3, 2 or 1) that fits.
- R8: A width above OUT_W is treated as OUT_W and a height above OUT_H as OUT_H.
- R9: A mode written with modeWe is used only from the cycle after the counters show hCount=0, vCount=OUT_H. The frame in progress keeps the old mode.
- R10: blankOut is the inverse of rdEn two cycles earlier. pixelOut equals rdData when blankOut is 0 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rstN | input | 1 | active-low synchronous reset |
| hCount | input | CW | horizontal pixel counter from the timing generator |
| vCount | input | CW | vertical line counter from the timing generator |
| activeIn | input | 1 | counters are inside the visible area |
| modeWe | input | 1 | one-cycle strobe that writes a guest mode |
| modeWidth | input | CW | guest width in pixels |
| modeHeight | input | CW | guest height in lines |
| modeScale | input | 2 | requested replication factor code |
| rdData | input | PIX_W | pixel returned by memory two cycles after rdAddr |
| rdAddr | output | AW | framebuffer read address |
| rdEn | output | 1 | read request for rdAddr |
| blankOut | output | 1 | pixel at pixelOut lies outside the window |
| pixelOut | output | PIX_W | pixel to the encoder, black in the border |

## Verification
The bench checks each address and enable against a reference computed from the requirements. It targets the window edges, where a design with an off-by-one in the origin or end compare would shift the picture or leave a one-pixel black seam. It runs factors 2 and 3, where a repeat counter that does not reset at the left edge would drift the picture, and a line base that advances every line would squash it vertically. It requests scales and sizes that do not fit, where a design without the fallback would read past the guest buffer. It also writes a mode in the middle of a frame, where a design that adopts it at once would tear that frame. Finally it checks the two-cycle blank alignment, since a wrong delay shows as colored border pixels or black picture edges.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

  // Per-pixel strobes from the window control to the address datapath.
  typedef struct packed {
    logic       hIn;      // horizontal position inside the window on a visible line
    logic       vIn;      // line inside the window rows
    logic       lineEnd;  // last window pixel of the current line
    logic       pixIn;    // pixel inside the window
    logic [1:0] repMax;   // replication factor minus one
  } scanStrobe_t;

endpackage

// File: rtl/winbox_ctrl.sv
module winbox_ctrl
  import scanout_pkg::*;
#(
  parameter int OUT_W = 1920,
  parameter int OUT_H = 1080,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] hCount,
  input  logic [CW-1:0] vCount,
  input  logic          activeIn,
  input  logic          modeWe,
  input  logic [CW-1:0] modeWidth,
  input  logic [CW-1:0] modeHeight,
  input  logic [1:0]    modeScale,
  output scanStrobe_t   strobe,
  output logic [CW-1:0] stride
);

  localparam int PW = CW + 2;  // room for three times a coordinate
  localparam logic [CW-1:0] OUT_W_C = CW'(OUT_W);
  localparam logic [CW-1:0] OUT_H_C = CW'(OUT_H);

  // ---- mode resolution at write time ----
  logic [CW-1:0] wClamp, hClamp;
  logic [PW-1:0] w2, h2, w3, h3, wSpan, hSpan;
  logic          fit2, fit3;
  logic [1:0]    effS;
  logic [CW-1:0] xOffNew, xEndNew, yOffNew, yEndNew;

  always_comb begin
    wClamp = (modeWidth  > OUT_W_C) ? OUT_W_C : modeWidth;
    hClamp = (modeHeight > OUT_H_C) ? OUT_H_C : modeHeight;
    w2 = PW'(wClamp) << 1;
    h2 = PW'(hClamp) << 1;
    w3 = w2 + PW'(wClamp);
    h3 = h2 + PW'(hClamp);
    fit2 = (w2 <= PW'(OUT_W)) && (h2 <= PW'(OUT_H));
    fit3 = (w3 <= PW'(OUT_W)) && (h3 <= PW'(OUT_H));
    case (modeScale)
      2'd2:    effS = fit2 ? 2'd2 : 2'd1;
      2'd3:    effS = fit3 ? 2'd3 : (fit2 ? 2'd2 : 2'd1);
      default: effS = 2'd1;
    endcase
    case (effS)
      2'd3:    begin wSpan = w3; hSpan = h3; end
      2'd2:    begin wSpan = w2; hSpan = h2; end
      default: begin wSpan = PW'(wClamp); hSpan = PW'(hClamp); end
    endcase
    xOffNew = CW'((PW'(OUT_W) - wSpan) >> 1);
    yOffNew = CW'((PW'(OUT_H) - hSpan) >> 1);
    xEndNew = CW'(PW'(xOffNew) + wSpan);
    yEndNew = CW'(PW'(yOffNew) + hSpan);
  end

  // ---- pending and active mode registers ----
  logic          pendValid;
  logic [CW-1:0] pendW, pendXOff, pendXEnd, pendYOff, pendYEnd;
  logic [1:0]    pendS;
  logic [CW-1:0] actW, actXOff, actXEnd, actYOff, actYEnd;
  logic [1:0]    actS;
  logic          vbStart;

  assign vbStart = (hCount == '0) && (vCount == OUT_H_C);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendW     <= OUT_W_C;
      pendS     <= 2'd1;
      pendXOff  <= '0;
      pendXEnd  <= OUT_W_C;
      pendYOff  <= '0;
      pendYEnd  <= OUT_H_C;
      actW      <= OUT_W_C;
      actS      <= 2'd1;
      actXOff   <= '0;
      actXEnd   <= OUT_W_C;
      actYOff   <= '0;
      actYEnd   <= OUT_H_C;
    end else begin
      if (vbStart && pendValid) begin
        actW      <= pendW;
        actS      <= pendS;
        actXOff   <= pendXOff;
        actXEnd   <= pendXEnd;
        actYOff   <= pendYOff;
        actYEnd   <= pendYEnd;
        pendValid <= 1'b0;
      end
      if (modeWe) begin
        pendW     <= wClamp;
        pendS     <= effS;
        pendXOff  <= xOffNew;
        pendXEnd  <= xEndNew;
        pendYOff  <= yOffNew;
        pendYEnd  <= yEndNew;
        pendValid <= 1'b1;
      end
    end
  end

  // ---- window decode ----
  logic hInC, vInC;
  always_comb begin
    hInC = activeIn && (hCount >= actXOff) && (hCount < actXEnd);
    vInC = (vCount >= actYOff) && (vCount < actYEnd);
    strobe.hIn     = hInC;
    strobe.vIn     = vInC;
    strobe.pixIn   = hInC && vInC;
    strobe.lineEnd = hInC && vInC && (hCount == actXEnd - CW'(1));
    strobe.repMax  = actS - 2'd1;
  end

  assign stride = actW;

  AST_MODE_AT_VBLANK: assert property (@(posedge clk) disable iff (!rstN)
    ((actS != $past(actS)) || (actXOff != $past(actXOff)) || (actYOff != $past(actYOff)))
      |-> $past(vbStart)) else $error("mode changed outside vblank start"); // R9

  AST_SCALE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    modeWe |=> (pendS != 2'd0)) else $error("illegal factor stored"); // R7

endmodule

// File: rtl/winbox_addr.sv
module winbox_addr
  import scanout_pkg::*;
#(
  parameter int CW     = 12,
  parameter int AW     = 21,
  parameter int PIX_W  = 24,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanStrobe_t      strobe,
  input  logic [CW-1:0]    stride,
  input  logic [PIX_W-1:0] rdData,
  output logic [AW-1:0]    rdAddr,
  output logic             rdEn,
  output logic             blankOut,
  output logic [PIX_W-1:0] pixelOut
);

  logic [1:0]    xRep, yRep;
  logic [CW-1:0] srcX;
  logic [AW-1:0] lineBase;

  // horizontal divide-by-S: restarts whenever the window is left
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.hIn) begin
      xRep <= '0;
      srcX <= '0;
    end else if (xRep == strobe.repMax) begin
      xRep <= '0;
      srcX <= srcX + CW'(1);
    end else begin
      xRep <= xRep + 2'd1;
    end
  end

  // vertical divide-by-S: the line base steps by the stride every S lines
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.vIn) begin
      yRep     <= '0;
      lineBase <= '0;
    end else if (strobe.lineEnd) begin
      if (yRep == strobe.repMax) begin
        yRep     <= '0;
        lineBase <= lineBase + AW'(stride);
      end else begin
        yRep <= yRep + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdEn   <= 1'b0;
      rdAddr <= '0;
    end else begin
      rdEn   <= strobe.pixIn;
      rdAddr <= strobe.pixIn ? (lineBase + AW'(srcX)) : '0;
    end
  end

  // enable delay line matched to the memory read latency
  logic [RD_LAT:0] enPipe;
  assign enPipe[0] = rdEn;
  for (genvar i = 1; i <= RD_LAT; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rstN) enPipe[i] <= 1'b0;
      else       enPipe[i] <= enPipe[i-1];
    end
  end

  assign blankOut = !enPipe[RD_LAT];
  assign pixelOut = enPipe[RD_LAT] ? rdData : '0;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn)) |-> ((rdAddr == $past(rdAddr)) || (rdAddr == $past(rdAddr) + AW'(1))))
    else $error("address jumped inside a line"); // R4

  AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (xRep <= strobe.repMax) && (yRep <= strobe.repMax))
    else $error("repeat counter beyond factor"); // R6

  if (RD_LAT == 2) begin : g_lag2
    AST_BLANK_LAG: assert property (@(posedge clk) disable iff (!rstN)
      !blankOut |-> $past(rdEn, 2)) else $error("blank not aligned to read"); // R10
  end

endmodule

// File: rtl/scanout_windowbox.sv
module scanout_windowbox
  import scanout_pkg::*;
#(
  parameter int OUT_W  = 1920,
  parameter int OUT_H  = 1080,
  parameter int CW     = 12,
  parameter int AW     = 21,
  parameter int PIX_W  = 24,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CW-1:0]    hCount,
  input  logic [CW-1:0]    vCount,
  input  logic             activeIn,
  input  logic             modeWe,
  input  logic [CW-1:0]    modeWidth,
  input  logic [CW-1:0]    modeHeight,
  input  logic [1:0]       modeScale,
  input  logic [PIX_W-1:0] rdData,
  output logic [AW-1:0]    rdAddr,
  output logic             rdEn,
  output logic             blankOut,
  output logic [PIX_W-1:0] pixelOut
);

  scanStrobe_t   strobe;
  logic [CW-1:0] stride;

  winbox_ctrl #(.OUT_W(OUT_W), .OUT_H(OUT_H), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount), .activeIn(activeIn),
    .modeWe(modeWe), .modeWidth(modeWidth), .modeHeight(modeHeight),
    .modeScale(modeScale), .strobe(strobe), .stride(stride)
  );

  winbox_addr #(.CW(CW), .AW(AW), .PIX_W(PIX_W), .RD_LAT(RD_LAT)) u_addr (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stride(stride), .rdData(rdData),
    .rdAddr(rdAddr), .rdEn(rdEn), .blankOut(blankOut), .pixelOut(pixelOut)
  );

  AST_NO_READ_IN_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> $past(activeIn)) else $error("read outside visible area"); // R2

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!rdEn && blankOut)) else $error("outputs active after reset"); // R1

endmodule

// File: tb/scanout_windowbox_test.sv
module scanout_windowbox_test;
  localparam int OW = 24, OH = 12, HT = 30, VT = 15;
  localparam int CW = 12, AW = 21, PXW = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic [CW-1:0] hCount = CW'(HT-1), vCount = CW'(VT-1);
  logic activeIn = 1'b0, modeWe = 1'b0;
  logic [CW-1:0] modeWidth = '0, modeHeight = '0;
  logic [1:0] modeScale = '0;
  logic [PXW-1:0] rdData = 24'h5a3c81;
  logic [AW-1:0] rdAddr;
  logic rdEn, blankOut;
  logic [PXW-1:0] pixelOut;

  scanout_windowbox #(.OUT_W(OW), .OUT_H(OH), .CW(CW), .AW(AW), .PIX_W(PXW)) uut (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount), .activeIn(activeIn),
    .modeWe(modeWe), .modeWidth(modeWidth), .modeHeight(modeHeight), .modeScale(modeScale),
    .rdData(rdData), .rdAddr(rdAddr), .rdEn(rdEn), .blankOut(blankOut), .pixelOut(pixelOut)
  );

  int checks = 0, fails = 0;
  int curW = OW, curH = OH, curS = 1, pendW = 0, pendH = 0, pendS = 1;
  bit pendV = 0;
  bit q1 = 0, q2 = 0, q3 = 0, prevAct = 0;
  int qa1 = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R7 R8: reference resolution of a written mode
  task automatic resolve(input int w, input int h, input int s,
                         output int ew, output int eh, output int es);
    ew = (w > OW) ? OW : w;
    eh = (h > OH) ? OH : h;
    if (s == 3 && 3*ew <= OW && 3*eh <= OH) es = 3;
    else if (s >= 2 && 2*ew <= OW && 2*eh <= OH) es = 2;
    else es = 1;
  endtask

  task automatic runFrame(input string tag, input int wrAt, input int w, input int h,
                          input int s, input int expCnt);
    int idx = 0, enCnt = 0;
    for (int v = 0; v < VT; v++) begin
      for (int hh = 0; hh < HT; hh++) begin
        int xo, yo, ex;
        bit act, win;
        @(negedge clk);
        chk(rdEn === q1, {tag, " R3 rdEn"}, int'(rdEn), int'(q1));
        if (q1) chk(rdAddr == AW'(qa1), {tag, " R4 rdAddr"}, int'(rdAddr), qa1);
        if (rdEn) chk(prevAct, {tag, " R2 read in blank"}, 1, 0);
        chk(blankOut === !q3, {tag, " R10 blankOut"}, int'(blankOut), int'(!q3));
        chk(pixelOut == (q3 ? rdData : '0), {tag, " R10 pixelOut"}, int'(pixelOut),
            q3 ? int'(rdData) : 0);
        enCnt += int'(rdEn);
        act = (hh < OW) && (v < OH);
        xo = (OW - curW*curS) / 2;
        yo = (OH - curH*curS) / 2;
        win = act && hh >= xo && hh < xo + curW*curS && v >= yo && v < yo + curH*curS;
        ex = win ? ((v - yo) / curS) * curW + (hh - xo) / curS : 0;
        q3 = q2; q2 = q1; q1 = win; qa1 = ex; prevAct = act;
        if (hh == 0 && v == OH && pendV) begin
          curW = pendW; curH = pendH; curS = pendS; pendV = 0;
        end
        hCount = CW'(hh); vCount = CW'(v); activeIn = act;
        modeWe = (idx == wrAt);
        if (idx == wrAt) begin
          modeWidth = CW'(w); modeHeight = CW'(h); modeScale = 2'(s);
          resolve(w, h, s, pendW, pendH, pendS);
          pendV = 1;
        end
        idx++;
      end
    end
    if (expCnt >= 0) chk(enCnt == expCnt, {tag, " read count"}, enCnt, expCnt);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(rdEn === 1'b0, "R1 rdEn in reset", int'(rdEn), 0);
    chk(blankOut === 1'b1, "R1 blankOut in reset", int'(blankOut), 1);
    chk(pixelOut == '0, "R1 pixelOut in reset", int'(pixelOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdEn === 1'b0 && blankOut === 1'b1, "R1 after reset", int'(rdEn), 0);
  endtask

  task automatic testDefault();
    runFrame("R1 default full", -1, 0, 0, 0, OW*OH);
  endtask

  task automatic testScale2();
    runFrame("R5 load", 5, OW/2, OH/2, 2, -1);
    runFrame("R5 half at x2", -1, 0, 0, 0, OW*OH);
  endtask

  task automatic testScale3();
    rdData = 24'h13f70e;
    runFrame("R6 load", 7, OW/3, OH/3, 3, -1);
    runFrame("R6 third at x3", -1, 0, 0, 0, OW*OH);
  endtask

  task automatic testCentred();
    runFrame("R3 load", 3, 10, 5, 1, -1);
    runFrame("R3 centred 10x5", -1, 0, 0, 0, 50);
  endtask

  task automatic testFallback();
    runFrame("R7 load", 3, 9, 5, 3, -1);
    runFrame("R7 x3 falls to x2", -1, 0, 0, 0, 180);
    runFrame("R7 load", 3, 6, 6, 0, -1);
    runFrame("R7 code0 is x1", -1, 0, 0, 0, 36);
  endtask

  task automatic testClamp();
    runFrame("R8 load", 3, 40, 20, 1, -1);
    runFrame("R8 oversize clamps", -1, 0, 0, 0, OW*OH);
    runFrame("R8 load", 3, 30, 5, 2, -1);
    runFrame("R8 wide clamp x1", -1, 0, 0, 0, OW*5);
  endtask

  task automatic testMidFrame();
    runFrame("R9 write mid-frame", 5*HT + 10, OW/2, OH/2, 2, OW*5);
    runFrame("R9 next frame", -1, 0, 0, 0, OW*OH);
  endtask

  bit finished = 0;

  initial begin
    testReset();
    testDefault();
    testScale2();
    testScale3();
    testCentred();
    testFallback();
    testClamp();
    testMidFrame();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule